// File: doc/BRIEF.md
# Interlocked Single-Line Interrupt Controller

This block holds the interrupt control for one external request line of a small processor. The request is brought into the clock domain, and each rising edge of it is latched into a pending flag. At every instruction boundary, signalled by a one-cycle end-of-instruction strobe, the block decides whether to divert the processor. A diversion is taken only when a request is pending and no service routine is already running.

When it diverts, the block records the program counter the processor presents and points the next fetch at a fixed vector address. It also raises an interlock flag and clears the pending flag. While the interlock is up, new request edges are kept in the pending flag but cannot restart the routine. The return strobe from the service routine drops the interlock while the saved address is still offered to the processor. A request that was held during service is then taken at the next instruction end.

Top module: `irq_lockctl_top`

## Requirements
- R1: After reset, take_o is low even with instr_end_i high and no request, and ret_addr_o reads zero.
- R2: A low-to-high transition on irq_req_i, after a two-cycle synchronizer, makes a request pending; take_o then rises in a cycle where instr_end_i is high.
- R3: take_o is never high in a cycle where instr_end_i is low, however long a request has been pending.
- R4: take_o stays low while a service routine is active, which is from the clock edge after a take until the edge that samples rti_i high.
- R5: At the clock edge where take_o is high, ret_addr_o captures pc_i, and it holds that value until the next take.
- R6: vector_o always equals the VEC_ADDR parameter (default 14'h0040).
- R7: A request edge that arrives during service is not lost; after return it is taken at the first cycle with instr_end_i high.
- R8: rti_i ends service at the edge that samples it, and ret_addr_o keeps the saved address through and after that cycle.
- R9: A request held high for many cycles counts as one event, and its falling edge counts as none.
- R10: If a new request edge is seen in the same cycle as a take, the request stays pending and is taken after the return.
- R11: A take consumes the pending request, so after return with no new edge, instr_end_i does not produce another take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | 1 | Asynchronous interrupt request line |
| instr_end_i | input | 1 | One-cycle strobe at the last cycle of each instruction |
| pc_i | input | ADDR_W | Current program address |
| rti_i | input | 1 | Service routine return strobe |
| take_o | output | 1 | Divert to the vector at this instruction boundary |
| vector_o | output | ADDR_W | Fixed service routine address |
| ret_addr_o | output | ADDR_W | Saved return address |

## Verification
The pending and interlock flags are internal, but each wrong value shows up on take_o at the next instruction end. A pending flag that is lost gives a missing take after return. One that is not cleared gives an extra take after return. An interlock that is stuck low lets a second take through during service, and one that is stuck high blocks the held request. A wrong capture shows up on ret_addr_o one cycle after the take and stays visible until the next take.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic pend;
    logic lock;
  } irq_flags_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int unsigned STAGES = irq_pkg::MIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_edge
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              level;

  generate
    if (STAGES < irq_pkg::MIN_SYNC_STAGES) begin : g_bad
      initial $error("irq_req_sync: STAGES below minimum");
    end
  endgenerate

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], req_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= level;
    end
  end

  assign level    = sync_q[STAGES-1];
  assign req_edge = level & ~last_q;

  // R9: one rising level yields a single-cycle event
  p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_edge |=> !req_edge);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_edge,
  input  logic instr_end,
  input  logic rti,
  output logic take
);
  irq_flags_t flags_q;
  irq_flags_t flags_d;

  assign take = instr_end & flags_q.pend & ~flags_q.lock;

  always_comb begin
    flags_d = flags_q;
    if (take)     flags_d.pend = 1'b0;
    if (req_edge) flags_d.pend = 1'b1;
    if (rti)      flags_d.lock = 1'b0;
    if (take)     flags_d.lock = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R4: entry raises the interlock
  p_entry_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> flags_q.lock);
  // R4: no take while locked
  p_no_take_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.lock |-> !take);
  // R8: return drops the interlock
  p_rti_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !take) |=> !flags_q.lock);
  // R10: a colliding edge keeps the request pending
  p_collide_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_edge) |=> flags_q.pend);
  // R11: plain entry consumes the request
  p_entry_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_edge) |=> !flags_q.pend);
endmodule

// File: rtl/irq_ret_store.sv
module irq_ret_store #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ret_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (cap_en) addr_d = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign ret_addr = addr_q;

  // R5: capture of the program address on entry
  p_ret_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> ret_addr == $past(pc));
  // R8: saved address unchanged without a new entry
  p_ret_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(ret_addr));
endmodule

// File: rtl/irq_lockctl_top.sv
module irq_lockctl_top #(
  parameter int unsigned       ADDR_W      = 14,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 14'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic              instr_end_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              rti_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [ADDR_W-1:0] ret_addr_o
);
  logic rst_int_n;
  logic req_edge;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_async (irq_req_i),
    .req_edge  (req_edge)
  );

  irq_flag_ctrl u_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_edge  (req_edge),
    .instr_end (instr_end_i),
    .rti       (rti_i),
    .take      (take_o)
  );

  irq_ret_store #(.ADDR_W(ADDR_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (take_o),
    .pc       (pc_i),
    .ret_addr (ret_addr_o)
  );

  assign vector_o = VEC_ADDR;

  // R3: diversion only at an instruction boundary
  p_take_at_end_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    take_o |-> instr_end_i);
endmodule

// File: tb/irq_lockctl_top_tb.sv
module irq_lockctl_top_tb;
  localparam int unsigned AW = 14;
  localparam logic [AW-1:0] VEC = 14'h0040;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq_req;
  logic          instr_end;
  logic [AW-1:0] pc;
  logic          rti;
  logic          take;
  logic [AW-1:0] vector;
  logic [AW-1:0] ret_addr;

  int total = 0;
  int bad   = 0;

  always #2ns clk = ~clk;

  irq_lockctl_top #(.ADDR_W(AW), .SYNC_STAGES(2), .VEC_ADDR(VEC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req_i   (irq_req),
    .instr_end_i (instr_end),
    .pc_i        (pc),
    .rti_i       (rti),
    .take_o      (take),
    .vector_o    (vector),
    .ret_addr_o  (ret_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_req();
    @(negedge clk); irq_req = 1'b1;
    cyc(2);
    @(negedge clk); irq_req = 1'b0;
    cyc(4);
  endtask

  // take a pending request at address a; checks take at the boundary
  task automatic enter(input string req, input logic [AW-1:0] a);
    @(negedge clk); pc = a; instr_end = 1'b1; #1;
    chk(req, 32'(take), 32'd1);
    @(negedge clk); instr_end = 1'b0; #1;
    chk("R5", 32'(ret_addr), 32'(a));
  endtask

  task automatic leave();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0; #1;
  endtask

  task automatic t_reset();
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R1", 32'(take), 32'd0);
    chk("R1", 32'(ret_addr), 32'd0);
    chk("R6", 32'(vector), 32'(VEC));
    @(negedge clk); instr_end = 1'b0;
  endtask

  task automatic t_basic();
    pulse_req();
    chk("R3", 32'(take), 32'd0);
    cyc(3);
    chk("R3", 32'(take), 32'd0);
    enter("R2", 14'h0123);
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R4", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0;
    leave();
  endtask

  task automatic t_hold();
    pulse_req();
    enter("R2", 14'h0200);
    pulse_req();
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R7", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0; rti = 1'b1; #1;
    chk("R8", 32'(ret_addr), 32'h0200);
    chk("R4", 32'(take), 32'd0);
    @(negedge clk); rti = 1'b0; #1;
    chk("R8", 32'(ret_addr), 32'h0200);
    enter("R7", 14'h0345);
    leave();
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R11", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0;
  endtask

  task automatic t_level();
    @(negedge clk); irq_req = 1'b1;
    cyc(5);
    enter("R2", 14'h0abc);
    leave();
    cyc(4);
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R9", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0; irq_req = 1'b0;
    cyc(5);
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R9", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0;
  endtask

  task automatic t_clear();
    pulse_req();
    enter("R2", 14'h1111);
    leave();
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R11", 32'(take), 32'd0);
    chk("R8", 32'(ret_addr), 32'h1111);
    @(negedge clk); instr_end = 1'b0;
  endtask

  task automatic t_collide();
    pulse_req();
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk);
    @(negedge clk); pc = 14'h2222; instr_end = 1'b1; #1;
    chk("R10", 32'(take), 32'd1);
    @(negedge clk); instr_end = 1'b0; irq_req = 1'b0;
    leave();
    enter("R10", 14'h3333);
    leave();
    @(negedge clk); instr_end = 1'b1; #1;
    chk("R11", 32'(take), 32'd0);
    @(negedge clk); instr_end = 1'b0;
  endtask

  initial begin
    #400us;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; instr_end = 1'b0; pc = '0; rti = 1'b0;
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_basic();
    t_hold();
    t_level();
    t_clear();
    t_collide();
    cyc(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule